// File: doc/BRIEF.md
# Program Counter and Return-Address Stack

This block holds the fetch address of a small 8-bit controller core that takes two clocks per instruction cycle. In each instruction cycle the decoder gives one operation request together with an advance strobe. The block then moves the program counter forward by one word, or sends it to a new address. The new address can come from a 10-bit immediate, from the accumulator, from the return-address stack, or from a fixed interrupt vector. The stack is built into the block and holds five return addresses.

Any change of the PC other than a sequential step costs the core one extra instruction cycle. The block tracks this with a two-state controller. `ST_RUN` is the normal state. The transition "redirect" takes the controller to `ST_FLUSH` whenever an accepted operation is not a plain step. While in `ST_FLUSH` the block raises `flush_req`, holds the PC and ignores operation requests. The transition "drain" returns the controller to `ST_RUN` on the next advance strobe, which marks the extra cycle as used up. Data-path writes to the PC (move and add) load only the low byte and clear the top two bits, so computed jumps stay inside the first 256 words.

Top module: `fetch_pc_unit`

## Requirements
- R1: While reset is active and just after it is released, `pc_out` is 0 and `flush_req` is 0. The reset vector is address 0.
- R2: The `op` encoding is one-hot: bit 0 step, bit 1 jump, bit 2 call, bit 3 return, bit 4 move accumulator, bit 5 add accumulator, bit 6 interrupt entry. An accepted step sets the PC to PC+1, wrapping from 1023 to 0. A step does not raise `flush_req`.
- R3: An accepted jump loads all ten bits of `imm` into the PC.
- R4: An accepted call loads `imm` into the PC and pushes PC+1 (the address of the call plus one, modulo 1024) onto the stack.
- R5: An accepted return loads the PC from the newest stack entry and removes that entry.
- R6: An accepted move sets PC[7:0] to `acc` and PC[9:8] to 0.
- R7: An accepted add sets PC[7:0] to the low byte of (PC[7:0] + `acc`) and PC[9:8] to 0.
- R8: An accepted interrupt entry pushes the current PC unchanged and loads the PC with the interrupt vector, 0x008 by default.
- R9: Each accepted operation other than a step moves the block to `ST_FLUSH`. `flush_req` is then 1 in the following cycle. `flush_req` stays 1 and the PC is held until the next cycle with `adv`=1; that cycle clears `flush_req`. Any operation presented during `ST_FLUSH` is ignored.
- R10: A push onto a stack that already holds five entries overwrites the oldest entry. The five most recent return addresses can still be popped, newest first.
- R11: A return on an empty stack loads the value returned by the most recent successful pop. If no pop has happened since reset, it loads 0.
- R12: With `adv`=0, or with `adv`=1 and `op`=0, the PC does not change and no flush is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Instruction-cycle advance strobe |
| op | input | 7 | One-hot operation request (encoding in R2) |
| imm | input | 10 | Immediate target for jump and call |
| acc | input | 8 | Accumulator value for move and add |
| pc_out | output | 10 | Current fetch address |
| flush_req | output | 1 | Request for one extra instruction cycle |

## Verification
Most faults in the PC register or the next-address logic show on `pc_out` one cycle after the operation is accepted. The bench therefore compares the PC after every single operation. Faults in the stack pointer, the fill count or the saved last-popped value stay hidden until a later return, so the bench runs nested call and interrupt sequences deeper than five and then pops past empty. The stack state only reaches `pc_out` when a value is popped. A fault in the flush controller shows as `flush_req` staying high too long or dropping too early, or as an operation that should have been ignored during the extra cycle moving the PC.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
    localparam int OP_N    = 7;
    localparam int OP_STEP = 0;
    localparam int OP_JUMP = 1;
    localparam int OP_CALL = 2;
    localparam int OP_RET  = 3;
    localparam int OP_MOV  = 4;
    localparam int OP_ADD  = 5;
    localparam int OP_INT  = 6;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } fpc_state_e;
endpackage

// File: rtl/fpc_next_calc.sv
`timescale 1ns/1ps
module fpc_next_calc
    import fpc_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8,
    parameter int unsigned INT_VEC = 8
) (
    input  logic [OP_N-1:0] op,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   imm,
    input  logic [DW-1:0]   acc,
    input  logic [AW-1:0]   pop_val,
    output logic [AW-1:0]   nxt_pc,
    output logic            push,
    output logic [AW-1:0]   push_val,
    output logic            pop,
    output logic            redirect
);
    localparam int HW = AW - DW;

    logic [AW-1:0] pc_inc;
    logic [DW-1:0] add_lo;

    assign pc_inc = pc + AW'(1);
    assign add_lo = pc[DW-1:0] + acc;

    always_comb begin
        nxt_pc   = pc;
        push     = 1'b0;
        push_val = pc_inc;
        pop      = 1'b0;
        redirect = 1'b0;
        unique case (1'b1)
            op[OP_STEP]: nxt_pc = pc_inc;
            op[OP_JUMP]: begin
                nxt_pc   = imm;
                redirect = 1'b1;
            end
            op[OP_CALL]: begin
                nxt_pc   = imm;
                push     = 1'b1;
                redirect = 1'b1;
            end
            op[OP_RET]: begin
                nxt_pc   = pop_val;
                pop      = 1'b1;
                redirect = 1'b1;
            end
            op[OP_MOV]: begin
                nxt_pc   = {{HW{1'b0}}, acc};
                redirect = 1'b1;
            end
            op[OP_ADD]: begin
                nxt_pc   = {{HW{1'b0}}, add_lo};
                redirect = 1'b1;
            end
            op[OP_INT]: begin
                nxt_pc   = AW'(INT_VEC);
                push     = 1'b1;
                push_val = pc;
                redirect = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpc_ret_stack.sv
`timescale 1ns/1ps
module fpc_ret_stack #(
    parameter int AW    = 10,
    parameter int DEPTH = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_val,
    input  logic                       pop,
    output logic [AW-1:0]              pop_val,
    output logic [$clog2(DEPTH+1)-1:0] depth
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] ent [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] top_ix;
    logic [CW-1:0] cnt;
    logic [AW-1:0] last_q;

    assign top_ix  = (wp == '0) ? PW'(DEPTH - 1) : wp - PW'(1);
    assign pop_val = (cnt != '0) ? ent[top_ix] : last_q;
    assign depth   = cnt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else if (push && wp == PW'(i)) begin
                ent[i] <= push_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp     <= '0;
            cnt    <= '0;
            last_q <= '0;
        end else if (push) begin
            wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (cnt != CW'(DEPTH)) begin
                cnt <= cnt + CW'(1);
            end
        end else if (pop && cnt != '0) begin
            wp     <= top_ix;
            cnt    <= cnt - CW'(1);
            last_q <= ent[top_ix];
        end
    end
endmodule

// File: rtl/fetch_pc_unit.sv
`timescale 1ns/1ps
module fetch_pc_unit
    import fpc_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 8,
    parameter int DEPTH = 5,
    parameter int unsigned INT_VEC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [OP_N-1:0] op,
    input  logic [AW-1:0]   imm,
    input  logic [DW-1:0]   acc,
    output logic [AW-1:0]   pc_out,
    output logic            flush_req
);
    localparam int CW = $clog2(DEPTH + 1);

    fpc_state_e    state_q, state_d;
    logic [AW-1:0] pc_q;
    logic          take;
    logic [AW-1:0] nxt_pc, push_val, pop_val;
    logic          push_req, pop_req, redirect;
    logic [CW-1:0] stk_depth;

    assign take = adv && (state_q == ST_RUN);

    fpc_next_calc #(.AW(AW), .DW(DW), .INT_VEC(INT_VEC)) u_calc (
        .op(op), .pc(pc_q), .imm(imm), .acc(acc), .pop_val(pop_val),
        .nxt_pc(nxt_pc), .push(push_req), .push_val(push_val),
        .pop(pop_req), .redirect(redirect)
    );

    fpc_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(take && push_req), .push_val(push_val),
        .pop(take && pop_req), .pop_val(pop_val),
        .depth(stk_depth)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (take && redirect) state_d = ST_FLUSH;
            ST_FLUSH: if (adv)              state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (take) begin
            pc_q <= nxt_pc;
        end
    end

    always_comb begin
        pc_out    = pc_q;
        flush_req = (state_q == ST_FLUSH);
    end
endmodule

// File: rtl/fpc_checker.sv
`timescale 1ns/1ps
module fpc_checker
    import fpc_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 8,
    parameter int DEPTH = 5,
    parameter int unsigned INT_VEC = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       adv,
    input logic [OP_N-1:0]            op,
    input logic [AW-1:0]              imm,
    input logic [DW-1:0]              acc,
    input logic [AW-1:0]              pc_out,
    input logic                       flush_req,
    input logic [$clog2(DEPTH+1)-1:0] depth
);
    localparam int HW = AW - DW;
    logic          run;
    logic [DW-1:0] sum_lo;
    assign run    = adv && !flush_req;
    assign sum_lo = pc_out[DW-1:0] + acc;

    AST_RESET_PC: assert property (@(posedge clk) $rose(rst_n) |-> (pc_out == '0 && !flush_req)); // R1
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_STEP] |=> (pc_out == $past(pc_out) + AW'(1)) && !flush_req); // R2
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_JUMP] |=> pc_out == $past(imm)); // R3
    AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_CALL] |=> pc_out == $past(imm)); // R4
    AST_RET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_RET] |=> flush_req); // R5
    AST_MOV_LOW: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_MOV] |=> pc_out == {{HW{1'b0}}, $past(acc)}); // R6
    AST_ADD_LOW: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_ADD] |=> pc_out == {{HW{1'b0}}, $past(sum_lo)}); // R7
    AST_INT_VEC: assert property (@(posedge clk) disable iff (!rst_n) run && op[OP_INT] |=> pc_out == AW'(INT_VEC)); // R8
    AST_FLUSH_WAIT: assert property (@(posedge clk) disable iff (!rst_n) flush_req && !adv |=> flush_req && pc_out == $past(pc_out)); // R9
    AST_FLUSH_END: assert property (@(posedge clk) disable iff (!rst_n) flush_req && adv |=> !flush_req && pc_out == $past(pc_out)); // R9
    AST_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_n) depth <= ($clog2(DEPTH+1))'(DEPTH)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !adv |=> pc_out == $past(pc_out)); // R12
    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) adv |-> $onehot0(op)); // R12
endmodule

bind fetch_pc_unit fpc_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .INT_VEC(INT_VEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .op(op), .imm(imm), .acc(acc),
    .pc_out(pc_out), .flush_req(flush_req), .depth(stk_depth)
);

// File: tb/sim_fetch_pc_unit.sv
`timescale 1ns/1ps
module sim_fetch_pc_unit;
    import fpc_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            adv = 1'b0;
    logic [OP_N-1:0] op = '0;
    logic [9:0]      imm = '0;
    logic [7:0]      acc = '0;
    logic [9:0]      pc_out;
    logic            flush_req;

    int n_chk = 0;
    int n_err = 0;
    int exp_pc = 0;
    int stk[$];
    int last_pop = 0;
    bit done = 0;

    fetch_pc_unit u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .op(op), .imm(imm), .acc(acc),
        .pc_out(pc_out), .flush_req(flush_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_push(input int v);
        stk.push_back(v);
        if (stk.size() > 5) stk.delete(0);
    endtask

    function automatic int model_pop();
        if (stk.size() > 0) last_pop = stk.pop_back();
        return last_pop;
    endfunction

    task automatic exec(input int k, input int iv, input int av, input string req);
        int nx;
        bit redir;
        redir = 1'b1;
        case (k)
            OP_STEP: begin nx = (exp_pc + 1) % 1024; redir = 1'b0; end
            OP_JUMP: nx = iv;
            OP_CALL: begin model_push((exp_pc + 1) % 1024); nx = iv; end
            OP_RET:  nx = model_pop();
            OP_MOV:  nx = av & 255;
            OP_ADD:  nx = (exp_pc + av) & 255;
            default: begin model_push(exp_pc); nx = 8; end
        endcase
        adv = 1'b1; op = OP_N'(1 << k); imm = 10'(iv); acc = 8'(av);
        @(negedge clk);
        adv = 1'b0; op = '0;
        exp_pc = nx;
        chk(req, int'(pc_out), exp_pc);
        chk({req, " flush"}, int'(flush_req), int'(redir));
        if (redir) begin
            adv = 1'b1;
            @(negedge clk);
            adv = 1'b0;
            chk("R9 drain", int'(flush_req), 0);
            chk("R9 hold", int'(pc_out), exp_pc);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", int'(pc_out), 0);
        chk("R1 flush in reset", int'(flush_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after reset", int'(pc_out), 0);
        chk("R1 flush after reset", int'(flush_req), 0);

        // R12: idle strobe and empty op
        op = OP_N'(1 << OP_JUMP); imm = 10'd77;
        repeat (3) @(negedge clk);
        chk("R12 adv low", int'(pc_out), 0);
        adv = 1'b1; op = '0;
        @(negedge clk);
        adv = 1'b0;
        chk("R12 empty op pc", int'(pc_out), 0);
        chk("R12 empty op flush", int'(flush_req), 0);

        // R11: pop on empty stack right after reset
        exec(OP_RET, 0, 0, "R11 empty pop after reset");

        for (int i = 0; i < 5; i++) exec(OP_STEP, 0, 0, "R2 step");

        // R3 and R2: sweep every jump target, then step (covers 1023 wrap)
        for (int a = 0; a < 1024; a++) begin
            exec(OP_JUMP, a, 0, "R3 jump");
            exec(OP_STEP, 0, 0, "R2 step after jump");
        end

        // R9: waiting in the flush state, ops ignored
        exec(OP_STEP, 0, 0, "R2 step");
        adv = 1'b1; op = OP_N'(1 << OP_JUMP); imm = 10'h155;
        @(negedge clk);
        adv = 1'b0; op = '0;
        exp_pc = 'h155;
        repeat (3) begin
            @(negedge clk);
            chk("R9 flush held", int'(flush_req), 1);
            chk("R9 pc held", int'(pc_out), exp_pc);
        end
        adv = 1'b1; op = OP_N'(1 << OP_JUMP); imm = 10'h2AA;
        @(negedge clk);
        adv = 1'b0; op = '0;
        chk("R9 op ignored", int'(pc_out), exp_pc);
        chk("R9 flush cleared", int'(flush_req), 0);

        // R6: move sweep from high addresses
        for (int a = 0; a < 256; a++) begin
            exec(OP_JUMP, 1023 - a, 0, "R3 jump");
            exec(OP_MOV, 0, a, "R6 move");
        end

        // R7: add sweep from several bases
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 256; a++) begin
                exec(OP_JUMP, (b * 331 + 171) % 1024, 0, "R3 jump");
                exec(OP_ADD, 0, a, "R7 add");
            end
        end

        // R4/R5: nesting depth 1..5
        for (int d = 1; d <= 5; d++) begin
            exec(OP_JUMP, 100 * d + 3, 0, "R3 jump");
            for (int i = 0; i < d; i++) exec(OP_CALL, 40 * i + 517, 0, "R4 call");
            for (int i = 0; i < d; i++) exec(OP_RET, 0, 0, "R5 return");
        end

        // R8: interrupt entry and return
        exec(OP_JUMP, 'h3F1, 0, "R3 jump");
        exec(OP_INT, 0, 0, "R8 interrupt vector");
        exec(OP_CALL, 'h200, 0, "R4 call in handler");
        exec(OP_RET, 0, 0, "R5 return from call");
        exec(OP_RET, 0, 0, "R8 return to interrupted pc");

        // R10/R11: overflow then pop past empty
        exec(OP_JUMP, 'h010, 0, "R3 jump");
        for (int i = 0; i < 7; i++) exec(OP_CALL, 'h080 + 3 * i, 0, "R10 call overflow");
        for (int i = 0; i < 5; i++) exec(OP_RET, 0, 0, "R10 return newest first");
        exec(OP_RET, 0, 0, "R11 empty pop repeats last");
        exec(OP_RET, 0, 0, "R11 empty pop again");
        exec(OP_INT, 0, 0, "R8 interrupt vector");
        exec(OP_RET, 0, 0, "R8 return");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule